// File: doc/BRIEF.md
# Self-Clocked Serial Bit Receiver

This block turns a single asynchronous, self-timed data line into clocked bit events. The line carries one mid-bit transition per bit (a rise for a one, a fall for a zero), with optional transitions at bit boundaries. The receiver brings the line into the master clock domain and learns the bit period from the stream itself. It then separates mid-bit transitions from boundary transitions and emits a one-cycle strobe with each decoded bit.

A frame opens with two bits of opposite value. The first mid-bit transition only starts the timing, and the second one yields both the first period estimate and the first delivered bit. Every later mid-bit transition refreshes the estimate, so slow drift in the sender's rate is followed. A line that stays silent for too long, or a mid-bit interval outside the legal 50 to 1000 cycle window, raises a one-cycle break pulse and drops the frame. The receiver listens only while the normal-mode enable is high. While it is low, the shared pin carries other traffic and is ignored.

Top module: `selfclk_rx`

## Requirements
- R1: The line passes through two synchroniser flops and a change detector, and the decision is registered once more. A mid-bit transition driven before clock edge k produces its bit_valid pulse in the cycle after edge k+2, and not earlier.
- R2: An accepted mid-bit transition from low to high decodes as 1 and from high to low decodes as 0. bit_valid is high for exactly one cycle, and bit_out keeps the last decoded value until the next one.
- R3: From idle, the first transition starts the measurement and produces no bit. The frame must open with two complementary bits. The next transition is taken as the second mid-bit edge: it stores the elapsed cycle count as the period and delivers the value of the second bit.
- R4: Once a period P exists, a transition counts as mid-bit only when the cycles since the previous mid-bit edge, times 4, exceed 3*P. Earlier transitions are boundary edges: they produce no pulse and leave bit_out unchanged.
- R5: Each accepted mid-bit edge replaces the period with the interval just measured. The later boundary and break thresholds use the new value.
- R6: A mid-bit interval below 50 or above 1000 cycles gives a one-cycle brk pulse instead of a bit and returns to idle. During the first measurement, reaching 1001 cycles without a transition does the same.
- R7: With a period learned, if no transition has been seen for H cycles and 2*H >= 3*P, brk pulses for one cycle and the receiver returns to idle.
- R8: When a transition arrives in the same cycle that the silence threshold of R7 is reached, the transition is processed and no break is raised. bit_valid and brk are never high together.
- R9: While normal_en is low, no bit_valid or brk is produced, and the receiver is forced idle. After re-enabling, it waits for a fresh first transition.
- R10: A synchronous active-high rst clears the outputs, the learned period and the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| normal_en | input | 1 | High while the shared pin carries the self-timed stream |
| line_in | input | 1 | Raw asynchronous data line |
| bit_out | output | 1 | Last decoded bit value |
| bit_valid | output | 1 | One-cycle strobe for a newly decoded bit |
| brk | output | 1 | One-cycle strobe for a break or framing error |

## Verification
Accepting a mid-bit transition and declaring a silent-line break can both be due in the same cycle. The bench learns a period of 100 cycles, then places the next transition exactly 150 cycles after the last one, so the transition lands on the cycle the silence count reaches the threshold. It expects a decoded bit there and no break. It repeats this with the stretched periods 150 and 225 to confirm that the threshold moves with each new estimate. A gap one cycle longer must instead produce a break in the cycle before the transition is seen. A cycle-accurate reference model compares bit_valid, brk and bit_out on every cycle around these points.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_FIRST = 2'd1,
        RX_RUN   = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic edge_seen;
        logic level;
    } line_ev_t;

    typedef struct packed {
        logic restart;
        logic clear;
    } timer_ctl_t;

    typedef struct packed {
        logic valid;
        logic value;
        logic brk;
    } rx_evt_t;

    function automatic int cnt_width(input int max_per);
        return $clog2(2 * max_per + 2);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync
    import rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign ev.level     = chain[LAST-1];
    assign ev.edge_seen = chain[LAST-1] ^ chain[LAST];

endmodule

// File: rtl/rx_timer.sv
`timescale 1ns/1ps
module rx_timer
    import rx_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  timer_ctl_t       ctl,
    input  logic             edge_seen,
    output logic [CNT_W-1:0] mid_cnt,
    output logic [CNT_W-1:0] hold_cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
        return (x == '1) ? x : x + ONE;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            mid_cnt  <= ctl.clear   ? '0 : (ctl.restart ? ONE : sat_inc(mid_cnt));
            hold_cnt <= ctl.clear   ? '0 : (edge_seen   ? ONE : sat_inc(hold_cnt));
        end
    end

endmodule

// File: rtl/rx_decider.sv
`timescale 1ns/1ps
module rx_decider
    import rx_pkg::*;
#(
    parameter int MIN_PER = 50,
    parameter int MAX_PER = 1000,
    parameter int CNT_W   = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  line_ev_t         ev,
    input  logic [CNT_W-1:0] mid_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    output rx_state_t        state,
    output logic [CNT_W-1:0] period,
    output timer_ctl_t       ctl,
    output rx_evt_t          evt
);
    localparam int W2 = CNT_W + 2;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PER);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PER);

    rx_state_t nxt;
    logic      load;
    logic [W2-1:0] mid_x4, per_x3, hold_x2;
    logic      in_range, is_mid, too_quiet, expired;

    assign mid_x4  = {mid_cnt, 2'b00};
    assign per_x3  = {1'b0, period, 1'b0} + {2'b00, period};
    assign hold_x2 = {1'b0, hold_cnt, 1'b0};

    assign in_range  = (mid_cnt >= MIN_C) && (mid_cnt <= MAX_C);
    assign is_mid    = (state == RX_FIRST) || (mid_x4 > per_x3);
    assign too_quiet = hold_x2 >= per_x3;
    assign expired   = (state == RX_FIRST) ? (mid_cnt > MAX_C) : too_quiet;

    always_comb begin
        nxt         = state;
        load        = 1'b0;
        ctl         = '0;
        evt         = '0;
        evt.value   = ev.level;
        if (!en) begin
            nxt       = RX_IDLE;
            ctl.clear = 1'b1;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (ev.edge_seen) begin
                        nxt         = RX_FIRST;
                        ctl.restart = 1'b1;
                    end else begin
                        ctl.clear = 1'b1;
                    end
                end
                RX_FIRST, RX_RUN: begin
                    if (ev.edge_seen) begin
                        if (is_mid) begin
                            if (in_range) begin
                                evt.valid   = 1'b1;
                                load        = 1'b1;
                                ctl.restart = 1'b1;
                                nxt         = RX_RUN;
                            end else begin
                                evt.brk   = 1'b1;
                                ctl.clear = 1'b1;
                                nxt       = RX_IDLE;
                            end
                        end
                    end else if (expired) begin
                        evt.brk   = 1'b1;
                        ctl.clear = 1'b1;
                        nxt       = RX_IDLE;
                    end
                end
                default: begin
                    nxt       = RX_IDLE;
                    ctl.clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            period <= '0;
        end else begin
            state <= nxt;
            if (load) period <= mid_cnt;
        end
    end

endmodule

// File: rtl/selfclk_rx.sv
`timescale 1ns/1ps
module selfclk_rx
    import rx_pkg::*;
#(
    parameter int MIN_PER     = 50,
    parameter int MAX_PER     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic normal_en,
    input  logic line_in,
    output logic bit_out,
    output logic bit_valid,
    output logic brk
);
    localparam int CNT_W = cnt_width(MAX_PER);

    line_ev_t         ev;
    timer_ctl_t       ctl;
    rx_evt_t          evt;
    rx_state_t        state;
    logic [CNT_W-1:0] mid_cnt, hold_cnt, period;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (line_in),
        .ev  (ev)
    );

    rx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .edge_seen (ev.edge_seen),
        .mid_cnt   (mid_cnt),
        .hold_cnt  (hold_cnt)
    );

    rx_decider #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .CNT_W(CNT_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .en       (normal_en),
        .ev       (ev),
        .mid_cnt  (mid_cnt),
        .hold_cnt (hold_cnt),
        .state    (state),
        .period   (period),
        .ctl      (ctl),
        .evt      (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            brk       <= 1'b0;
        end else begin
            bit_valid <= evt.valid;
            brk       <= evt.brk;
            if (evt.valid) bit_out <= evt.value;
        end
    end

endmodule

// File: rtl/rx_checks.sv
`timescale 1ns/1ps
module rx_checks
    import rx_pkg::*;
#(
    parameter int MIN_PER = 50,
    parameter int MAX_PER = 1000,
    parameter int CNT_W   = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             normal_en,
    input logic             bit_valid,
    input logic             bit_out,
    input logic             brk,
    input logic             level,
    input rx_state_t        state,
    input logic [CNT_W-1:0] period
);
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && brk));                                         // R8

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);                                    // R2

    AST_BIT_FROM_LINE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (bit_out == $past(level)));                     // R2

    AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        brk |=> !brk);                                                // R6

    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (bit_valid || brk) |-> $past(normal_en));                     // R9

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (state == RX_RUN) |-> (period >= CNT_W'(MIN_PER) && period <= CNT_W'(MAX_PER))); // R5

endmodule

bind selfclk_rx rx_checks #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .normal_en (normal_en),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .brk       (brk),
    .level     (ev.level),
    .state     (state),
    .period    (period)
);

// File: tb/sim_selfclk_rx.sv
`timescale 1ns/1ps
module sim_selfclk_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic normal_en = 1'b0;
    logic line_in = 1'b0;
    logic bit_out, bit_valid, brk;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R10";
    bit armed = 1'b0;
    bit done = 1'b0;

    int n_got = 0;
    int n_brk = 0;
    logic got_bits [0:63];

    selfclk_rx u0 (
        .clk(clk), .rst(rst), .normal_en(normal_en), .line_in(line_in),
        .bit_out(bit_out), .bit_valid(bit_valid), .brk(brk)
    );

    always #2.5 clk = ~clk;

    // reference model built from the requirements
    logic s_a = 0, s_b = 0, s_c = 0;
    int m_state = 0, m_mid = 0, m_hold = 0, m_per = 0;
    logic e_valid = 0, e_brk = 0, e_bit = 0;

    always @(posedge clk) begin
        if (rst) begin
            s_a = 0; s_b = 0; s_c = 0;
            m_state = 0; m_mid = 0; m_hold = 0; m_per = 0;
            e_valid = 0; e_brk = 0; e_bit = 0;
        end else begin
            logic e, lv, v, b, rs, cl, ld;
            int nx;
            e = s_b ^ s_c; lv = s_b;
            v = 0; b = 0; rs = 0; cl = 0; ld = 0; nx = m_state;
            if (!normal_en) begin
                nx = 0; cl = 1;
            end else if (m_state == 0) begin
                if (e) begin nx = 1; rs = 1; end else cl = 1;
            end else begin
                if (e) begin
                    if (m_state == 1 || m_mid * 4 > m_per * 3) begin
                        if (m_mid >= 50 && m_mid <= 1000) begin
                            v = 1; rs = 1; ld = 1; nx = 2;
                        end else begin
                            b = 1; cl = 1; nx = 0;
                        end
                    end
                end else if ((m_state == 1) ? (m_mid > 1000) : (m_hold * 2 >= m_per * 3)) begin
                    b = 1; cl = 1; nx = 0;
                end
            end
            e_valid = v; e_brk = b;
            if (v) e_bit = lv;
            if (ld) m_per = m_mid;
            m_mid  = cl ? 0 : (rs ? 1 : ((m_mid < 2047) ? m_mid + 1 : m_mid));
            m_hold = cl ? 0 : (e ? 1 : ((m_hold < 2047) ? m_hold + 1 : m_hold));
            m_state = nx;
            s_c = s_b; s_b = s_a; s_a = line_in;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison and event capture
    always @(negedge clk) begin
        if (armed && !done) begin
            check({bit_valid, brk, bit_out} == {e_valid, e_brk, e_bit}, cur_req,
                  {bit_valid, brk, bit_out}, {e_valid, e_brk, e_bit});
            if (bit_valid) begin
                if (n_got < 64) got_bits[n_got] = bit_out;
                n_got++;
            end
            if (brk) n_brk++;
        end
    end

    task automatic drive(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_in = lvl;
        end
    endtask

    task automatic clear_counts();
        n_got = 0; n_brk = 0;
    endtask

    task automatic send_frame(input int per, input int nbits, input logic [31:0] bits, input int jit);
        for (int i = 0; i < nbits; i++) begin
            int p, h;
            p = per;
            if (jit > 0) p = per - jit + int'($urandom_range(2 * jit, 0));
            h = p / 2;
            drive(~bits[i], h);
            drive(bits[i], p - h);
        end
    endtask

    task automatic check_bits(input string req, input int nbits, input logic [31:0] bits);
        check(n_got == nbits - 1, req, n_got, nbits - 1);
        for (int i = 1; i < nbits && i <= 64; i++)
            check(got_bits[i-1] == bits[i], req, got_bits[i-1], bits[i]);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        cur_req = "R10";
        check({bit_valid, brk, bit_out} == 3'b000, "R10 reset state", {bit_valid, brk, bit_out}, 0);

        // R1 latency and R3 first delivered bit
        cur_req = "R1";
        normal_en = 1'b1;
        drive(0, 10);
        clear_counts();
        drive(1, 60);
        @(negedge clk); line_in = 0;
        @(negedge clk); @(negedge clk);
        check(bit_valid == 1'b0, "R1 no early strobe", bit_valid, 0);
        @(negedge clk);
        check(bit_valid == 1'b1, "R1 strobe two syncs plus one", bit_valid, 1);
        check(bit_out == 1'b0, "R3 second bit delivered", bit_out, 0);
        cur_req = "R7";
        drive(0, 120);
        check(n_brk == 1, "R7 silence break", n_brk, 1);

        // R2 R4: frame with repeated bits from idle low
        cur_req = "R4";
        clear_counts();
        send_frame(60, 8, 32'h4D, 0);
        check_bits("R2 R4 decoded values", 8, 32'h4D);
        drive(0, 130);
        check(n_brk == 1, "R7 break after frame", n_brk, 1);

        // R6: interval too short; later edge restarts and times out
        cur_req = "R6";
        clear_counts();
        send_frame(40, 3, 32'h5, 0);
        drive(1, 1100);
        check(n_got == 0, "R6 short interval no bit", n_got, 0);
        check(n_brk == 2, "R6 short interval break", n_brk, 2);

        // R6: interval too long during first measurement
        clear_counts();
        send_frame(1100, 2, 32'h2, 0);
        drive(1, 1100);
        check(n_got == 0, "R6 long interval no bit", n_got, 0);
        check(n_brk == 2, "R6 first measurement timeout", n_brk, 2);

        // R6: late mid edge while running
        clear_counts();
        send_frame(900, 3, 32'h2, 0);
        drive(0, 600);
        drive(1, 50);
        check(n_got == 2, "R6 bits before late edge", n_got, 2);
        check(n_brk == 1, "R6 late edge break", n_brk, 1);
        drive(1, 1100);
        check(n_brk == 1, "R6 idle after late break", n_brk, 1);

        // R8 R5: edge on the silence threshold wins; threshold tracks period
        cur_req = "R8";
        clear_counts();
        send_frame(100, 2, 32'h2, 0);
        drive(1, 100);
        drive(0, 20);
        check(n_got == 2 && n_brk == 0, "R8 edge at threshold gives bit", n_got, 2);
        drive(0, 205);
        drive(1, 5);
        check(n_got == 3 && n_brk == 0, "R5 threshold follows new period", n_got, 3);
        check(got_bits[1] == 1'b0 && got_bits[2] == 1'b1, "R2 values at threshold", got_bits[2], 1);
        drive(1, 334);
        drive(0, 10);
        check(n_brk == 1 && n_got == 3, "R8 one past threshold breaks", n_brk, 1);
        drive(0, 1100);
        check(n_brk == 2, "R6 restart then timeout", n_brk, 2);

        // R9: disabled receiver ignores the line and is idle afterwards
        cur_req = "R9";
        clear_counts();
        send_frame(80, 3, 32'h5, 0);
        check(n_got == 2, "R9 frame before disable", n_got, 2);
        normal_en = 1'b0;
        clear_counts();
        drive(0, 40); drive(1, 40); drive(0, 40); drive(1, 1500);
        check(n_got == 0 && n_brk == 0, "R9 no events while disabled", n_got + n_brk, 0);
        normal_en = 1'b1;
        drive(1, 1100);
        check(n_brk == 0, "R9 idle after enable", n_brk, 0);

        // random frames with jitter
        cur_req = "R5";
        begin
            logic lvl;
            lvl = 1'b1;
            for (int f = 0; f < 8; f++) begin
                int per, nb;
                logic [31:0] fb;
                per = 60 + int'($urandom_range(240, 0));
                nb  = 6 + int'($urandom_range(8, 0));
                fb  = $urandom;
                fb[0] = ~lvl; fb[1] = lvl;
                clear_counts();
                send_frame(per, nb, fb, per / 16);
                check_bits("R2 R5 random frame", nb, fb);
                drive(fb[nb-1], 2 * per);
                check(n_brk == 1, "R7 random frame end break", n_brk, 1);
                lvl = fb[nb-1];
            end
        end

        // R10: reset in mid frame clears state
        cur_req = "R10";
        drive(0, 10);
        clear_counts();
        send_frame(60, 2, 32'h1, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check({bit_valid, brk, bit_out} == 3'b000, "R10 outputs cleared", {bit_valid, brk, bit_out}, 0);
        rst = 1'b0;
        clear_counts();
        drive(0, 200);
        check(n_brk == 0 && n_got == 0, "R10 idle after reset", n_brk + n_got, 0);

        finish_run();
    end
endmodule